// File: doc/BRIEF.md
# Video Gain Tracking Loop

This block closes the automatic gain loop of a video decoder front end. Once per video line it is given two averaged ADC codes, one from the sync tip window and one from the back porch window, plus the peak code seen on the line. It compares the back porch minus sync tip difference with one of two fixed targets and integrates the error into an unsigned gain word that drives the front-end amplifier.

A line that reaches full scale can force the gain down, whatever the sync error says. A freeze control stops tracking and passes a manual gain word straight to the output. The loop speed comes from a 2-bit time-constant field. An optional acquisition mode doubles the loop speed until lock is declared. Lock is declared after a run of lines with small error and cleared after a run of lines with large error.

Top module: `vid_agc_loop`

## Requirements
- R1: After reset the gain output is 128 and the locked output is 0.
- R2: On each line_end pulse, while not frozen and without a clip override, the difference porch_avg minus tip_avg is compared with a target of 68 when tgt_sel is 0 or 54 when tgt_sel is 1. The error is target minus difference. The gain changes by that error arithmetically shifted right by 2, 3, 4 or 5 for tc_sel values 0 to 3. The new gain is visible on the clock edge that samples line_end.
- R3: When the error is positive but the shifted correction is zero, the gain rises by 1. Because the shift is arithmetic, a small negative error always yields a correction of at least -1.
- R4: When ovf_en is 1 and peak_code equals 255 on a line_end, the gain drops by 4 instead of following the error. When ovf_en is 0, the peak code has no effect.
- R5: The gain saturates at 0 and at 255 and never wraps.
- R6: Without a line_end pulse, the gain does not change while not frozen.
- R7: While freeze is 1, the gain output takes manual_gain one clock later and follows it. line_end pulses are ignored for tracking.
- R8: When freeze returns to 0, tracking resumes from the manual gain value and locked is cleared on that edge.
- R9: locked becomes 1 on the 8th consecutive unfrozen line whose absolute error is 2 or less. Once set, it becomes 0 on the 8th consecutive line whose absolute error exceeds 8. Lines in between keep the flag unchanged. The error is counted even on clip lines.
- R10: When fast_en is 1 and locked is 0, the shift is one less than R2 gives. Once locked is 1, the normal shift applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_end | input | 1 | One-cycle strobe marking the end of a line's measurements |
| tip_avg | input | 8 | Averaged ADC code from the sync tip window |
| porch_avg | input | 8 | Averaged ADC code from the back porch window |
| peak_code | input | 8 | Highest ADC code seen during the line |
| tgt_sel | input | 1 | Target pair select: 0 gives difference 68, 1 gives 54 |
| ovf_en | input | 1 | Enables gain reduction on full-scale lines |
| freeze | input | 1 | Stops tracking and outputs manual_gain |
| manual_gain | input | 8 | Gain value used while frozen |
| tc_sel | input | 2 | Loop time-constant select |
| fast_en | input | 1 | Halves the time constant until lock |
| gain | output | 8 | Registered gain word |
| locked | output | 1 | Registered lock flag |

## Verification
The error path is driven with zero error, with positive and negative errors under every time-constant value, and with both target sets. These cases separate the shift amounts and the arithmetic shift from a logical one, and they show which of the two targets is in use. Tiny errors on both sides expose the minimum-step rule. Full-scale lines with the protection on and off show that the clip override takes priority over the error. Runs of exactly seven and eight good or bad lines pin down the lock thresholds. The freeze, release and saturation sequences check that tracking resumes from the manual gain and that the gain clamps rather than wraps.

// File: rtl/vid_agc_loop.sv
module vid_agc_loop #(
  parameter int DW         = 8,
  parameter int GAIN_INIT  = 128,
  parameter int TGT_LOW    = 68,
  parameter int TGT_HIGH   = 54,
  parameter int CLIP_STEP  = 4,
  parameter int BASE_SHIFT = 2,
  parameter int RUN_LINES  = 8,
  parameter int GOOD_TOL   = 2,
  parameter int BAD_TOL    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic [DW-1:0] tip_avg,
  input  logic [DW-1:0] porch_avg,
  input  logic [DW-1:0] peak_code,
  input  logic          tgt_sel,
  input  logic          ovf_en,
  input  logic          freeze,
  input  logic [DW-1:0] manual_gain,
  input  logic [1:0]    tc_sel,
  input  logic          fast_en,
  output logic [DW-1:0] gain,
  output logic          locked
);

  localparam int EW  = DW + 2;
  localparam int SW  = DW + 3;
  localparam int CW  = $clog2(RUN_LINES + 1);
  localparam logic [DW-1:0] FULL = {DW{1'b1}};
  localparam logic [CW-1:0] LAST = CW'(RUN_LINES - 1);

  logic signed [EW-1:0] diff_s, tgt_s, err_s, corr_raw;
  logic        [EW-1:0] abs_err;
  logic        [2:0]    shamt;
  logic signed [SW-1:0] corr, sum;
  logic        [DW-1:0] gain_nx;
  logic                 clip, good, bad, freeze_q;
  logic        [CW-1:0] good_cnt, bad_cnt;

  assign diff_s  = $signed({2'b00, porch_avg}) - $signed({2'b00, tip_avg});
  assign tgt_s   = tgt_sel ? EW'(TGT_HIGH) : EW'(TGT_LOW);
  assign err_s   = tgt_s - diff_s;
  assign abs_err = err_s[EW-1] ? EW'(-err_s) : EW'(err_s);
  assign shamt   = 3'(BASE_SHIFT) + {1'b0, tc_sel} - ((fast_en && !locked) ? 3'd1 : 3'd0);
  assign corr_raw = err_s >>> shamt;
  assign clip    = ovf_en && (peak_code == FULL);
  assign good    = abs_err <= EW'(GOOD_TOL);
  assign bad     = abs_err >  EW'(BAD_TOL);

  always_comb begin
    if (clip)
      corr = -SW'(CLIP_STEP);
    else if (err_s != '0 && corr_raw == '0)
      corr = SW'(1);
    else
      corr = SW'(corr_raw);
    sum = $signed({3'b000, gain}) + corr;
    if (sum < 0)
      gain_nx = '0;
    else if (sum > $signed({3'b000, FULL}))
      gain_nx = FULL;
    else
      gain_nx = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain     <= DW'(GAIN_INIT);
      freeze_q <= 1'b0;
    end else begin
      freeze_q <= freeze;
      if (freeze)
        gain <= manual_gain;
      else if (line_end)
        gain <= gain_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (freeze) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (freeze_q) begin
      locked   <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (line_end) begin
      good_cnt <= good ? ((good_cnt == LAST) ? good_cnt : good_cnt + 1'b1) : '0;
      bad_cnt  <= bad  ? ((bad_cnt  == LAST) ? bad_cnt  : bad_cnt  + 1'b1) : '0;
      if (good && good_cnt == LAST) locked <= 1'b1;
      if (bad  && bad_cnt  == LAST) locked <= 1'b0;
    end
  end

  assert_freeze_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> gain == $past(manual_gain));

  assert_clip_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !freeze && ovf_en && peak_code == FULL) |=> gain <= $past(gain));

  assert_hold_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_end && !freeze) |=> $stable(gain));

  assert_release_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze) |=> !locked);

  assert_lock_on_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_end));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !freeze && !clip && err_s > 0) |=> gain >= $past(gain));

endmodule

// File: tb/vid_agc_loop_bench.sv
module vid_agc_loop_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_end = 1'b0;
  logic [7:0] tip_avg = 8'd2, porch_avg = 8'd70, peak_code = 8'd0;
  logic       tgt_sel = 1'b0, ovf_en = 1'b0, freeze = 1'b0, fast_en = 1'b0;
  logic [7:0] manual_gain = 8'd0;
  logic [1:0] tc_sel = 2'd0;
  logic [7:0] gain;
  logic       locked;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_agc_loop u_vid_agc_loop (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .tip_avg(tip_avg),
    .porch_avg(porch_avg), .peak_code(peak_code), .tgt_sel(tgt_sel),
    .ovf_en(ovf_en), .freeze(freeze), .manual_gain(manual_gain),
    .tc_sel(tc_sel), .fast_en(fast_en), .gain(gain), .locked(locked)
  );

  localparam int NV = 10;
  localparam int V_TIP [NV]  = '{2,   2,   2,  16,  16,   2,   2,   2,   2, 100};
  localparam int V_POR [NV]  = '{70,  50,  90, 70,  60,  71,  50,  50,  10,   2};
  localparam int V_PEAK[NV]  = '{0,   0,   0,   0,   0,   0, 255, 255,   0,   0};
  localparam int V_TSEL[NV]  = '{0,   0,   0,   1,   1,   0,   0,   0,   0,   0};
  localparam int V_OVF [NV]  = '{0,   0,   0,   0,   0,   0,   1,   0,   0,   0};
  localparam int V_TC  [NV]  = '{0,   0,   1,   0,   3,   3,   0,   0,   0,   0};
  localparam int V_GAIN[NV]  = '{128, 133, 130, 130, 131, 130, 126, 131, 146, 187};

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; freeze = 1'b0; line_end = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic line(int tp, int pc, int pk);
    @(negedge clk);
    tip_avg = 8'(tp); porch_avg = 8'(pc); peak_code = 8'(pk); line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic set_manual(int g);
    @(negedge clk); freeze = 1'b1; manual_gain = 8'(g);
    @(negedge clk); freeze = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 gain", gain, 128);
    check("R1 locked", locked, 0);

    for (int i = 0; i < NV; i++) begin
      tgt_sel = V_TSEL[i][0]; ovf_en = V_OVF[i][0]; tc_sel = 2'(V_TC[i]);
      line(V_TIP[i], V_POR[i], V_PEAK[i]);
      check($sformatf("R2/R3/R4 vector %0d", i), gain, V_GAIN[i]);
    end
    ovf_en = 1'b0; tgt_sel = 1'b0; tc_sel = 2'd0;

    repeat (5) @(negedge clk);
    check("R6 gain idle", gain, 187);

    set_manual(250);
    line(100, 2, 0);
    check("R5 high saturation", gain, 255);
    set_manual(2);
    ovf_en = 1'b1;
    line(2, 70, 255);
    check("R5 low saturation on clip", gain, 0);
    line(2, 50, 255);
    check("R5 stays at zero", gain, 0);
    ovf_en = 1'b0;

    do_reset();
    for (int i = 0; i < 7; i++) line(2, 70, 0);
    check("R9 not locked after 7", locked, 0);
    line(2, 72, 0);
    check("R9 locked after 8 (err -2)", locked, 1);
    for (int i = 0; i < 7; i++) line(2, 50, 0);
    check("R9 still locked after 7 bad", locked, 1);
    line(2, 50, 0);
    check("R9 unlocked after 8 bad", locked, 0);

    do_reset();
    fast_en = 1'b1;
    line(2, 50, 0);
    check("R10 fast step", gain, 138);
    for (int i = 0; i < 8; i++) line(2, 70, 0);
    check("R10 locked", locked, 1);
    line(2, 50, 0);
    check("R10 normal step once locked", gain, 143);

    @(negedge clk); freeze = 1'b1; manual_gain = 8'd77;
    @(negedge clk);
    check("R7 manual gain", gain, 77);
    check("R7 lock held while frozen", locked, 1);
    line(2, 10, 0);
    check("R7 line ignored", gain, 77);
    manual_gain = 8'd90;
    @(negedge clk);
    check("R7 follows manual", gain, 90);
    freeze = 1'b0;
    @(negedge clk);
    check("R8 lock cleared", locked, 0);
    check("R8 gain kept", gain, 90);
    line(2, 50, 0);
    check("R8 resumes from manual", gain, 100);
    fast_en = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule